// File: doc/BRIEF.md
# Period-Reset Timer with Conversion Trigger

This block is a 16-bit up-counter reached over a byte-wide register bus. It counts either every cycle of the system clock or rising edges of an external clock input. Every count source passes through a divide-by-1/2/4/8 prescaler. The external input is sampled either through a two-stage synchroniser (synchronous counter mode) or through a single sampling stage (asynchronous counter mode). When the counter rolls over from 0xFFFF to 0x0000, it sets a sticky overflow flag. That flag drives an interrupt request output gated by an enable bit, and a separate priority output.

A 16-bit compare register sits alongside the counter. When trigger mode is on and the counter equals the compare value, the block raises a one-cycle event pulse. The same pulse requests an ADC conversion when the ADC-enable input is high, and it returns the counter to zero. The compare register therefore sets the period of the count. A bus write that loads the counter in the same cycle overrides the return to zero. In asynchronous counter mode the return to zero is withheld.

A 16-bit access mode keeps multi-byte reads and writes coherent. Reading the low byte captures the high byte for a later read. A high-byte write is held in a buffer and lands together with the next low-byte write.

Top module: `cmp_period_timer`

## Requirements
- R1: After reset every register reads 0x00, and trig_o, adc_start_o, ovf_irq_o and ovf_prio_o are low.
- R2: Register map by bus_addr: 0 control, 1 count low byte, 2 count high byte, 3 compare low byte, 4 compare high byte, 5 interrupt (bit0 overflow flag, bit1 interrupt enable, bit2 priority). Control, compare and the enable/priority bits read back as written, and addresses 6 and 7 read 0x00. Control bits: bit0 run, bit1 external source, bit2 external sync bypass (asynchronous mode), bits 4:3 prescale code, bit5 trigger mode, bit7 16-bit access mode.
- R3: With the internal source, a running counter advances once every N cycles, where prescale codes 0, 1, 2 and 3 give N = 1, 2, 4 and 8. Any counter load or trigger clear restarts the prescaler.
- R4: With the external source, the count source is a rising edge of ext_clk. With bit2 = 0 the edge is seen after two sampling stages; with bit2 = 1 it is seen after one.
- R5: While run is 0 the counter and prescaler hold their values, and trig_o and adc_start_o stay low.
- R6: In trigger mode, a running counter equal to the compare value raises trig_o for exactly one cycle. The pulse re-arms only after the counter has differed from the compare value.
- R7: trig_o returns the counter to zero in the next cycle, so the count repeats 0..compare. In asynchronous external mode the counter is not cleared.
- R8: adc_start_o is high exactly when trig_o is high and adc_en is high.
- R9: A write that loads the counter in the same cycle as trig_o is taken, and the clear is discarded; the trigger pulse itself still occurs. Loading writes are a low-byte write in either mode, or a high-byte write in 8-bit mode.
- R10: The overflow flag is set only by a count step from 0xFFFF to 0x0000, and never by a trigger clear. It stays set until a write to address 5 with bit0 = 0. ovf_irq_o is flag AND enable, and ovf_prio_o is the priority bit.
- R11: In 16-bit mode, a read strobe on the low byte captures the high byte, and reads of address 2 return that captured value.
- R12: In 16-bit mode, a high-byte write leaves the counter unchanged. It is committed together with the next low-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count input |
| adc_en | input | 1 | ADC enabled; gates the conversion request |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect in 16-bit mode) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| trig_o | output | 1 | Compare-match event pulse |
| adc_start_o | output | 1 | ADC conversion-start pulse |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| ovf_prio_o | output | 1 | Overflow interrupt priority |

## Verification
The two functions that can fall in one cycle are the trigger clear and a loading bus write. Each also collides with a count step or a rollover. The bench restarts the counter at zero with a compare value of 5, waits five cycles, and writes the low byte in the exact cycle the counter sits on the compare value. It then expects the trigger pulse in that cycle and the written value, not zero, in the next. A second case sets the compare value to 0xFFFF so that the trigger clear replaces the rollover step, and expects the overflow flag to stay clear.

// File: rtl/cmp_period_timer.sv
module cmp_period_timer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          adc_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          trig_o,
  output logic          adc_start_o,
  output logic          ovf_irq_o,
  output logic          ovf_prio_o
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CLO  = AW'(1);
  localparam logic [AW-1:0] A_CHI  = AW'(2);
  localparam logic [AW-1:0] A_PLO  = AW'(3);
  localparam logic [AW-1:0] A_PHI  = AW'(4);
  localparam logic [AW-1:0] A_IRQ  = AW'(5);

  logic [DW-1:0] ctrl_q, hi_wbuf_q, hi_rbuf_q;
  logic [CW-1:0] cnt_q, cmp_q;
  logic [2:0]    pre_q, sy_q;
  logic [1:0]    as_q;
  logic          armed_q, flag_q, ien_q, prio_q;

  wire run     = ctrl_q[0];
  wire src_ext = ctrl_q[1];
  wire nosync  = ctrl_q[2];
  wire [1:0] psc = ctrl_q[4:3];
  wire trig_en = ctrl_q[5];
  wire wide    = ctrl_q[7];

  wire s_edge   = sy_q[1] & ~sy_q[2];
  wire a_edge   = as_q[0] & ~as_q[1];
  wire src_tick = src_ext ? (nosync ? a_edge : s_edge) : 1'b1;
  wire adv      = run & src_tick;
  wire [2:0] pre_lim = {psc == 2'd3, psc[1], |psc};
  wire step     = adv & (pre_q >= pre_lim);

  wire wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  wire wr_clo  = bus_wr & (bus_addr == A_CLO);
  wire wr_chi  = bus_wr & (bus_addr == A_CHI);
  wire wr_plo  = bus_wr & (bus_addr == A_PLO);
  wire wr_phi  = bus_wr & (bus_addr == A_PHI);
  wire wr_irq  = bus_wr & (bus_addr == A_IRQ);

  logic cnt_load;
  assign cnt_load = wr_clo | (wr_chi & ~wide);
  wire [CW-1:0] load_val = wr_clo ? {(wide ? hi_wbuf_q : cnt_q[CW-1:DW]), bus_wdata}
                                  : {bus_wdata, cnt_q[DW-1:0]};

  assign trig_o      = run & trig_en & armed_q & (cnt_q == cmp_q);
  assign adc_start_o = trig_o & adc_en;
  wire clr  = trig_o & ~(src_ext & nosync);
  wire roll = step & ~cnt_load & ~clr & (&cnt_q);

  assign ovf_irq_o  = flag_q & ien_q;
  assign ovf_prio_o = prio_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_CLO:   bus_rdata = cnt_q[DW-1:0];
      A_CHI:   bus_rdata = wide ? hi_rbuf_q : cnt_q[CW-1:DW];
      A_PLO:   bus_rdata = cmp_q[DW-1:0];
      A_PHI:   bus_rdata = cmp_q[CW-1:DW];
      A_IRQ:   bus_rdata = {{(DW-3){1'b0}}, prio_q, ien_q, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hi_wbuf_q <= '0;
      hi_rbuf_q <= '0;
      cnt_q     <= '0;
      cmp_q     <= '0;
      pre_q     <= '0;
      sy_q      <= '0;
      as_q      <= '0;
      armed_q   <= 1'b1;
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      prio_q    <= 1'b0;
    end else begin
      sy_q <= {sy_q[1:0], ext_clk};
      as_q <= {as_q[0], ext_clk};
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_plo) cmp_q[DW-1:0]  <= bus_wdata;
      if (wr_phi) cmp_q[CW-1:DW] <= bus_wdata;
      if (wr_chi & wide) hi_wbuf_q <= bus_wdata;
      if (bus_rd & (bus_addr == A_CLO) & wide) hi_rbuf_q <= cnt_q[CW-1:DW];

      if (cnt_load)  cnt_q <= load_val;
      else if (clr)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + CW'(1);

      if (cnt_load | clr) pre_q <= '0;
      else if (adv)       pre_q <= step ? 3'd0 : pre_q + 3'd1;

      if (trig_o)              armed_q <= 1'b0;
      else if (cnt_q != cmp_q) armed_q <= 1'b1;

      flag_q <= roll | (flag_q & ~(wr_irq & ~bus_wdata[0]));
      if (wr_irq) begin
        ien_q  <= bus_wdata[1];
        prio_q <= bus_wdata[2];
      end
    end
  end
endmodule

// File: rtl/cmp_period_timer_chk.sv
module cmp_period_timer_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_o,
  input logic            adc_start_o,
  input logic            adc_en,
  input logic [DW-1:0]   ctrl,
  input logic [2*DW-1:0] cnt,
  input logic            ovf_flag,
  input logic            cnt_load,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata
);
  // R8
  adc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> (trig_o && adc_en));

  // R6
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !cnt_load) |=> (cnt == $past(cnt)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> (!trig_o && !adc_start_o));

  // R7
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !cnt_load && !(ctrl[1] && ctrl[2])) |=> (cnt == '0));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && bus_wr && bus_addr == AW'(1) && !ctrl[7]) |=> (cnt[DW-1:0] == $past(bus_wdata)));

  // R10
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt) == '1 && cnt == '0));
endmodule

bind cmp_period_timer cmp_period_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .adc_start_o(adc_start_o),
  .adc_en(adc_en), .ctrl(ctrl_q), .cnt(cnt_q), .ovf_flag(flag_q),
  .cnt_load(cnt_load), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
);

// File: tb/cmp_period_timer_tb_top.sv
module cmp_period_timer_tb_top;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, ext_clk = 0, adc_en = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 3'd1;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire trig_o, adc_start_o, ovf_irq_o, ovf_prio_o;

  cmp_period_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .adc_en(adc_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trig_o(trig_o), .adc_start_o(adc_start_o),
    .ovf_irq_o(ovf_irq_o), .ovf_prio_o(ovf_prio_o)
  );

  always #(PERIOD/2) clk = ~clk;

  logic [7:0]  m_ctrl = 0, m_wbuf = 0, m_rbuf = 0;
  logic [15:0] m_cnt = 0, m_cmp = 0;
  int m_pre = 0;
  bit m_armed = 1, m_flag = 0, m_ien = 0, m_prio = 0;
  bit hq[$];

  int errors = 0, checks = 0;
  string cur_req = "R1";
  int ext_half = 0, ext_ctr = 0;
  int trig_seen = 0, adc_seen = 0;
  logic [7:0] last_rd;

  function automatic void check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  task automatic tick();
    bit run, ext, nos, ten, wide, sedge, aedge, src, adv, stp, e_trig, clr, wlo, whi, ld;
    int lim;
    logic [7:0] e_rd;
    logic [15:0] n_cnt;
    if (ext_half > 0) begin
      ext_ctr++;
      if (ext_ctr >= ext_half) begin ext_clk = ~ext_clk; ext_ctr = 0; end
    end
    #1;
    run = m_ctrl[0]; ext = m_ctrl[1]; nos = m_ctrl[2]; ten = m_ctrl[5]; wide = m_ctrl[7];
    sedge = hq[1] && !hq[2];
    aedge = hq[0] && !hq[1];
    src = ext ? (nos ? aedge : sedge) : 1'b1;
    adv = run && src;
    lim = (1 << m_ctrl[4:3]) - 1;
    stp = adv && (m_pre >= lim);
    e_trig = run && ten && m_armed && (m_cnt == m_cmp);
    case (bus_addr)
      3'd0: e_rd = m_ctrl;
      3'd1: e_rd = m_cnt[7:0];
      3'd2: e_rd = wide ? m_rbuf : m_cnt[15:8];
      3'd3: e_rd = m_cmp[7:0];
      3'd4: e_rd = m_cmp[15:8];
      3'd5: e_rd = {5'b0, m_prio, m_ien, m_flag};
      default: e_rd = 8'h00;
    endcase
    check(cur_req, "trig_o", int'(trig_o), int'(e_trig));
    check(cur_req, "adc_start_o", int'(adc_start_o), int'(e_trig && adc_en));
    check(cur_req, "bus_rdata", int'(bus_rdata), int'(e_rd));
    check(cur_req, "ovf_irq_o", int'(ovf_irq_o), int'(m_flag && m_ien));
    check(cur_req, "ovf_prio_o", int'(ovf_prio_o), int'(m_prio));
    if (trig_o) trig_seen++;
    if (adc_start_o) adc_seen++;
    last_rd = bus_rdata;

    wlo = bus_wr && bus_addr == 3'd1;
    whi = bus_wr && bus_addr == 3'd2;
    ld  = wlo || (whi && !wide);
    clr = e_trig && !(ext && nos);
    if (ld) n_cnt = wlo ? {(wide ? m_wbuf : m_cnt[15:8]), bus_wdata} : {bus_wdata, m_cnt[7:0]};
    else if (clr) n_cnt = 16'h0000;
    else if (stp) n_cnt = m_cnt + 16'h1;
    else n_cnt = m_cnt;

    @(posedge clk);
    if (stp && !ld && !clr && m_cnt == 16'hFFFF) m_flag = 1;
    else if (bus_wr && bus_addr == 3'd5 && !bus_wdata[0]) m_flag = 0;
    if (bus_wr && bus_addr == 3'd5) begin m_ien = bus_wdata[1]; m_prio = bus_wdata[2]; end
    if (ld || clr) m_pre = 0;
    else if (adv) m_pre = stp ? 0 : m_pre + 1;
    if (e_trig) m_armed = 0;
    else if (m_cnt != m_cmp) m_armed = 1;
    if (bus_rd && bus_addr == 3'd1 && wide) m_rbuf = m_cnt[15:8];
    if (whi && wide) m_wbuf = bus_wdata;
    if (bus_wr && bus_addr == 3'd3) m_cmp[7:0] = bus_wdata;
    if (bus_wr && bus_addr == 3'd4) m_cmp[15:8] = bus_wdata;
    if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata;
    m_cnt = n_cnt;
    hq.push_front(ext_clk);
    if (hq.size() > 3) void'(hq.pop_back());
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
    bus_wr = 0; bus_addr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a);
    bus_addr = a; bus_rd = 1;
    tick();
    bus_rd = 0; bus_addr = 3'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int maxv;
    logic [7:0] held;
    hq = '{0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    rd(3'd0); check("R1", "ctrl after reset", int'(last_rd), 0);
    rd(3'd1); check("R1", "count low after reset", int'(last_rd), 0);
    rd(3'd2); check("R1", "count high after reset", int'(last_rd), 0);
    rd(3'd5); check("R1", "irq reg after reset", int'(last_rd), 0);

    cur_req = "R2";
    wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    rd(3'd3); check("R2", "compare low readback", int'(last_rd), 'h34);
    rd(3'd4); check("R2", "compare high readback", int'(last_rd), 'h12);
    rd(3'd7); check("R2", "unmapped address", int'(last_rd), 0);
    wr(3'd0, 8'h40); rd(3'd0); check("R2", "ctrl readback", int'(last_rd), 'h40);
    wr(3'd0, 8'h00);

    cur_req = "R3";
    for (int ps = 0; ps < 4; ps++) begin
      wr(3'd0, 8'h01 | 8'(ps << 3));
      wr(3'd1, 8'h00);
      idle(8 << ps);
      rd(3'd1);
      check("R3", $sformatf("8 steps at prescale code %0d", ps), int'(last_rd), 8);
    end

    cur_req = "R5";
    wr(3'd0, 8'h00);
    rd(3'd1); held = last_rd;
    idle(10);
    rd(3'd1); check("R5", "count held while stopped", int'(last_rd), int'(held));

    cur_req = "R10";
    wr(3'd2, 8'hFF); wr(3'd1, 8'hF8); wr(3'd5, 8'h06);
    rd(3'd5); check("R10", "enable and priority set, flag clear", int'(last_rd), 'h06);
    wr(3'd0, 8'h01);
    idle(12);
    rd(3'd5); check("R10", "flag set by rollover", int'(last_rd), 'h07);
    check("R10", "irq output asserted", int'(ovf_irq_o), 1);
    check("R10", "priority output", int'(ovf_prio_o), 1);
    wr(3'd5, 8'h06);
    rd(3'd5); check("R10", "flag cleared by write of 0", int'(last_rd), 'h06);
    wr(3'd5, 8'h00);

    cur_req = "R6";
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd3, 8'h05);
    adc_en = 1;
    wr(3'd0, 8'h21);
    wr(3'd1, 8'h00);
    trig_seen = 0; adc_seen = 0;
    idle(60);
    check("R6", "trigger pulses in 60 cycles at period 6", trig_seen, 10);
    check("R8", "adc pulses with adc enabled", adc_seen, 10);
    cur_req = "R7";
    adc_en = 0; adc_seen = 0; maxv = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (int'(last_rd) > maxv) maxv = int'(last_rd);
    end
    check("R7", "count never exceeds compare value", maxv, 5);
    check("R8", "no adc pulse with adc disabled", adc_seen, 0);

    cur_req = "R9";
    wr(3'd1, 8'h00);
    idle(5);
    trig_seen = 0;
    wr(3'd1, 8'h42);
    check("R9", "trigger still fires on collision", trig_seen, 1);
    rd(3'd1); check("R9", "written value wins over clear", int'(last_rd), 'h42);

    cur_req = "R11";
    wr(3'd0, 8'h00); wr(3'd4, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h80);
    wr(3'd2, 8'h12); wr(3'd1, 8'hFE);
    wr(3'd0, 8'h81);
    rd(3'd1); check("R11", "low byte read", int'(last_rd), 'hFE);
    idle(4);
    rd(3'd2); check("R11", "captured high byte", int'(last_rd), 'h12);

    cur_req = "R12";
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    wr(3'd0, 8'h80); wr(3'd2, 8'hAB);
    wr(3'd0, 8'h00);
    rd(3'd2); check("R12", "high write buffered only", int'(last_rd), 0);
    wr(3'd0, 8'h80); wr(3'd1, 8'hCD); wr(3'd0, 8'h00);
    rd(3'd2); check("R12", "high byte committed", int'(last_rd), 'hAB);
    rd(3'd1); check("R12", "low byte committed", int'(last_rd), 'hCD);

    cur_req = "R4";
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    ext_half = 3; ext_ctr = 0;
    wr(3'd0, 8'h03);
    idle(60);
    rd(3'd1); check("R4", "sync ext edges counted", int'(last_rd >= 9 && last_rd <= 11), 1);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd0, 8'h07);
    idle(60);
    rd(3'd1); check("R4", "async ext edges counted", int'(last_rd >= 9 && last_rd <= 11), 1);

    cur_req = "R7";
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd3, 8'h03); wr(3'd1, 8'h00);
    wr(3'd0, 8'h27);
    idle(60);
    rd(3'd1); check("R7", "async mode passes compare uncleared", int'(last_rd >= 6), 1);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd0, 8'h23);
    maxv = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (int'(last_rd) > maxv) maxv = int'(last_rd);
    end
    check("R7", "sync ext mode cleared at compare", maxv, 3);
    ext_half = 0;

    cur_req = "R10";
    wr(3'd0, 8'h00); wr(3'd5, 8'h02);
    wr(3'd4, 8'hFF); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'hFC);
    wr(3'd0, 8'h21);
    idle(12);
    rd(3'd5); check("R10", "trigger clear does not set flag", int'(last_rd), 'h02);

    finish_run();
  end
endmodule